// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block collects eight interrupt lines and passes one at a time to a processor. Each line is latched on its rising edge into a request register. A mask register filters the requests, and the remaining ones compete under a fixed priority against the levels already in service. When a pending line outranks everything in service, the block raises an interrupt output.

The processor answers with two acknowledge pulses. The first pulse freezes the winner and marks it in service. The second pulse returns an 8-bit vector, built from a programmable base and the line number.

Software reaches the block through a two-address register port: a command address and a data address. It programs the block with a four-step setup sequence. After that it controls the block with commands that:
- load the mask;
- end service of a level, either a named level or the highest one in service;
- choose whether reads of the command address return the request register or the in-service register.

The setup sequence also stores the cascade word, which is a slave bitmap on a master or the identity on a slave. An auto-acknowledge mode drops the need for software end-of-service commands.

Top module: `pic_core`

## Requirements
- R1: After reset the request and in-service registers are zero, the mask is 0xFF, command-address reads return the request register, and `int_out` is low.
- R2: A command write of 0x11 starts setup. The next three data-address writes are stored in order as the vector base, the cascade word (shown on `cascade_cfg`) and the mode word. These writes leave the mask unchanged. Setup also clears the request latches and the in-service register.
- R3: The returned vector is base bits [7:3] followed by the 3-bit line number. A base of 0x20 yields 0x20..0x27, and a base of 0x28 yields 0x28..0x2F.
- R4: Outside setup, a data-address write loads the mask (bit n masks line n), and data-address reads return it. A masked line never raises `int_out`.
- R5: Priority is fixed, with line 0 highest. `int_out` is high only while some unmasked request has a lower line number than every set in-service bit.
- R6: The first `inta` pulse sets the winner's in-service bit and clears its request. The second pulse makes `vec_valid` high with the vector on `vec_out` in the following cycle.
- R7: When mode word bit 1 is set, the second `inta` pulse clears the in-service bit of the acknowledged level.
- R8: A command write of 0x0A selects request-register readback, and 0x0B selects in-service readback. The selection persists until it is changed. The request register shows latched lines that are still high.
- R9: A command write of 0x60+L (L = 0..7) clears in-service bit L only.
- R10: A command write of 0x20 clears the lowest-numbered set in-service bit.
- R11: If no request qualifies at the first `inta` pulse, the vector is base|7 and the in-service register is not changed. This holds even when line 7 is masked.
- R12: A line held high raises one request only. It must fall and rise again to request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = command address, 1 = data address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | 0 = command address, 1 = data address |
| rd_data | output | 8 | Read data (request, in-service or mask) |
| inta | input | 1 | Acknowledge pulse, two per interrupt |
| int_out | output | 1 | Interrupt to the processor |
| vec_valid | output | 1 | Vector valid, one cycle |
| vec_out | output | 8 | Interrupt vector |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
The bench walks every line under two vector bases and every ordered pair of simultaneous lines. A priority encoder that is reversed, or that ignores the in-service register, would return the wrong vector or raise `int_out` while a higher level is in service. It also drops a request between the interrupt and the acknowledge while line 7 is masked. A design that skipped the spurious path would set an in-service bit or return a live level instead of base|7. Finally it checks a held line, a non-specific end with two levels in service, and auto-acknowledge mode. A design that re-triggered on level, or cleared the wrong in-service bit, would leave `int_out` or the in-service readback wrong.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      CFG_RUN  = 2'd0,
      CFG_BASE = 2'd1,
      CFG_CASC = 2'd2,
      CFG_MODE = 2'd3
   } cfg_state_t;

   localparam logic [7:0] CMD_SETUP   = 8'h11;
   localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
   localparam logic [7:0] CMD_SEL_ISV = 8'h0B;
   localparam logic [7:0] CMD_END_TOP = 8'h20;
   localparam logic [4:0] CMD_END_LVL = 5'b01100;
   localparam int         MODE_AUTO_BIT = 1;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
   import pic_pkg::*;
#(
   parameter int DW = 8,
   parameter int LW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-LW-1:0] base_hi,
   output logic [DW-1:0] casc_word,
   output logic          auto_end,
   output logic [DW-1:0] mask,
   output logic          sel_isv,
   output logic          run,
   output logic          setup_clr,
   output logic          end_lvl_hit,
   output logic [LW-1:0] end_lvl,
   output logic          end_top_hit
);
   cfg_state_t state;
   logic cmd_wr, dat_wr;

   assign cmd_wr      = wr_en && !wr_addr;
   assign dat_wr      = wr_en && wr_addr;
   assign run         = (state == CFG_RUN);
   assign setup_clr   = cmd_wr && (wr_data == CMD_SETUP);
   assign end_lvl_hit = cmd_wr && run && (wr_data[DW-1:LW] == CMD_END_LVL);
   assign end_lvl     = wr_data[LW-1:0];
   assign end_top_hit = cmd_wr && run && (wr_data == CMD_END_TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= CFG_RUN;
         base_hi   <= '0;
         casc_word <= '0;
         auto_end  <= 1'b0;
         mask      <= '1;
         sel_isv   <= 1'b0;
      end else if (setup_clr) begin
         state   <= CFG_BASE;
         sel_isv <= 1'b0;
      end else if (cmd_wr && run) begin
         if (wr_data == CMD_SEL_REQ) sel_isv <= 1'b0;
         if (wr_data == CMD_SEL_ISV) sel_isv <= 1'b1;
      end else if (dat_wr) begin
         case (state)
            CFG_BASE: begin
               base_hi <= wr_data[DW-1:LW];
               state   <= CFG_CASC;
            end
            CFG_CASC: begin
               casc_word <= wr_data;
               state     <= CFG_MODE;
            end
            CFG_MODE: begin
               auto_end <= wr_data[MODE_AUTO_BIT];
               state    <= CFG_RUN;
            end
            default: mask <= wr_data;
         endcase
      end
   end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int LINES = 8,
   parameter int LW    = 3
) (
   input  logic [LINES-1:0] req_i,
   input  logic [LINES-1:0] isv_i,
   output logic             grant_o,
   output logic [LW-1:0]    lvl_o,
   output logic             isv_any_o,
   output logic [LW-1:0]    isv_top_o
);
   logic req_any;

   always_comb begin
      req_any   = 1'b0;
      lvl_o     = '0;
      isv_any_o = 1'b0;
      isv_top_o = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            req_any = 1'b1;
            lvl_o   = LW'(i);
         end
         if (isv_i[i]) begin
            isv_any_o = 1'b1;
            isv_top_o = LW'(i);
         end
      end
      grant_o = req_any && (!isv_any_o || (lvl_o < isv_top_o));
   end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
   parameter int LINES = 8,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] irq_in,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic             rd_addr,
   output logic [DW-1:0]    rd_data,
   input  logic             inta,
   output logic             int_out,
   output logic             vec_valid,
   output logic [DW-1:0]    vec_out,
   output logic [DW-1:0]    cascade_cfg
);
   localparam int LW = $clog2(LINES);
   localparam int VW = DW - LW;

   if (LINES != 8 || DW != 8) begin : g_bad_cfg
      $error("pic_core supports LINES=8 and DW=8 only");
   end

   logic [VW-1:0]    base_hi;
   logic [DW-1:0]    mask_r;
   logic             auto_end, sel_isv, run, setup_clr;
   logic             end_lvl_hit, end_top_hit;
   logic [LW-1:0]    end_lvl;
   logic [LINES-1:0] prev_q, lat_q, irr, isr_q, isr_d;
   logic             grant, isv_any;
   logic [LW-1:0]    win_lvl, isv_top;
   logic             ack_phase, held_spur, ack_first, ack_second;
   logic [LW-1:0]    held_lvl;

   pic_cfg #(.DW(DW), .LW(LW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .base_hi(base_hi), .casc_word(cascade_cfg),
      .auto_end(auto_end), .mask(mask_r), .sel_isv(sel_isv), .run(run),
      .setup_clr(setup_clr), .end_lvl_hit(end_lvl_hit), .end_lvl(end_lvl),
      .end_top_hit(end_top_hit)
   );

   pic_prio #(.LINES(LINES), .LW(LW)) u_prio (
      .req_i(irr & ~mask_r), .isv_i(isr_q), .grant_o(grant),
      .lvl_o(win_lvl), .isv_any_o(isv_any), .isv_top_o(isv_top)
   );

   assign ack_first  = inta && !ack_phase;
   assign ack_second = inta && ack_phase;
   assign irr        = lat_q & irq_in;
   assign int_out    = grant;
   assign rd_data    = rd_addr ? mask_r : (sel_isv ? isr_q : irr);

   for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q[g] <= 1'b0;
            lat_q[g]  <= 1'b0;
         end else begin
            prev_q[g] <= irq_in[g];
            if (setup_clr || (ack_first && grant && win_lvl == LW'(g)))
               lat_q[g] <= 1'b0;
            else
               lat_q[g] <= (lat_q[g] | (irq_in[g] & ~prev_q[g])) & irq_in[g];
         end
      end
   end

   always_comb begin
      isr_d = isr_q;
      if (ack_first && grant) isr_d[win_lvl] = 1'b1;
      if (ack_second && auto_end && !held_spur) isr_d[held_lvl] = 1'b0;
      if (end_lvl_hit) isr_d[end_lvl] = 1'b0;
      if (end_top_hit && isv_any) isr_d[isv_top] = 1'b0;
      if (setup_clr) isr_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q     <= '0;
         ack_phase <= 1'b0;
         held_lvl  <= '0;
         held_spur <= 1'b0;
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         isr_q     <= isr_d;
         vec_valid <= 1'b0;
         if (ack_first) begin
            ack_phase <= 1'b1;
            held_lvl  <= grant ? win_lvl : LW'(LINES - 1);
            held_spur <= !grant;
         end else if (ack_second) begin
            ack_phase <= 1'b0;
            vec_valid <= 1'b1;
            vec_out   <= {base_hi, held_lvl};
         end
      end
   end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
   parameter int LINES = 8,
   parameter int DW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_addr,
   input logic [DW-1:0]    wr_data,
   input logic             inta,
   input logic             int_out,
   input logic             vec_valid,
   input logic [DW-1:0]    vec_out,
   input logic             ack_phase,
   input logic             run,
   input logic [DW-$clog2(LINES)-1:0] base_hi,
   input logic [LINES-1:0] irr,
   input logic [DW-1:0]    mask_r,
   input logic [LINES-1:0] isr_q
);
   localparam int LW = $clog2(LINES);

   assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> |(irr & ~mask_r[LINES-1:0]));

   assert_vec_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> vec_out[DW-1:LW] == base_hi);

   assert_vec_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && ack_phase) |=> vec_valid);

   assert_ack_sets_isv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !ack_phase && int_out && !wr_en) |=> |(isr_q & ~$past(isr_q)));

   assert_spurious_keeps_isv_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !ack_phase && !int_out && !wr_en) |=> isr_q == $past(isr_q));

   assert_specific_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && run && wr_data[DW-1:LW] == 5'b01100)
         |=> !isr_q[$past(wr_data[LW-1:0])]);
endmodule

bind pic_core pic_core_chk #(.LINES(LINES), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .inta(inta), .int_out(int_out),
   .vec_valid(vec_valid), .vec_out(vec_out), .ack_phase(ack_phase),
   .run(run), .base_hi(base_hi), .irr(irr), .mask_r(mask_r), .isr_q(isr_q)
);

// File: tb/sim_pic_core.sv
`timescale 1ns/1ps
module sim_pic_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0, inta = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data, vec_out, cascade_cfg;
   logic       int_out, vec_valid;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   pic_core u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .inta(inta), .int_out(int_out),
      .vec_valid(vec_valid), .vec_out(vec_out), .cascade_cfg(cascade_cfg)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic setup(input logic [7:0] base, input logic [7:0] casc, input logic [7:0] mode);
      wr(1'b0, 8'h11); wr(1'b1, base); wr(1'b1, casc); wr(1'b1, mode);
   endtask

   task automatic rd_cmd(input logic [7:0] sel, output logic [7:0] v);
      wr(1'b0, sel);
      rd_addr = 1'b0; #1 v = rd_data;
   endtask

   task automatic rd_mask(output logic [7:0] v);
      rd_addr = 1'b1; #1 v = rd_data; rd_addr = 1'b0;
   endtask

   task automatic do_ack(input string tag, input logic [7:0] exp_vec);
      @(negedge clk); inta = 1'b1;
      @(negedge clk); inta = 1'b0;
      @(negedge clk); inta = 1'b1;
      @(negedge clk); inta = 1'b0;
      check({tag, " vec_valid"}, {7'd0, vec_valid}, 8'h01);
      check({tag, " vector"}, vec_out, exp_vec);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 int_out", {7'd0, int_out}, 8'h00);
      rd_mask(v);  check("R1 mask", v, 8'hFF);
      rd_addr = 1'b0; #1 check("R1 default request readback", rd_data, 8'h00);

      // R2 setup writes do not touch the mask
      wr(1'b1, 8'h5A);
      setup(8'h20, 8'h04, 8'h01);
      check("R2 cascade word", cascade_cfg, 8'h04);
      rd_mask(v); check("R2 mask kept", v, 8'h5A);

      // R3 R5 R6 R8 R9 R12: every line under two bases
      for (int b = 0; b < 2; b++) begin
         base = (b == 0) ? 8'h20 : 8'h28;
         setup(base, (b == 0) ? 8'h04 : 8'h02, 8'h01);
         check("R2 cascade word", cascade_cfg, (b == 0) ? 8'h04 : 8'h02);
         wr(1'b1, 8'h00);
         for (int l = 0; l < 8; l++) begin
            irq_in = 8'(1 << l);
            @(negedge clk);
            check("R5 int_out single", {7'd0, int_out}, 8'h01);
            rd_cmd(8'h0A, v); check("R8 request readback", v, 8'(1 << l));
            do_ack("R3 R6", base + 8'(l));
            rd_cmd(8'h0B, v); check("R6 in-service set", v, 8'(1 << l));
            rd_cmd(8'h0A, v); check("R6 request cleared", v, 8'h00);
            check("R12 held line no retrigger", {7'd0, int_out}, 8'h00);
            wr(1'b0, 8'h60 + 8'(l));
            rd_cmd(8'h0B, v); check("R9 specific end", v, 8'h00);
            irq_in = '0;
            @(negedge clk);
         end
      end

      // R5 every ordered pair
      for (int i = 0; i < 8; i++) begin
         for (int j = i + 1; j < 8; j++) begin
            irq_in = 8'((1 << i) | (1 << j));
            @(negedge clk);
            do_ack("R5 pair winner", 8'h28 + 8'(i));
            check("R5 lower blocked", {7'd0, int_out}, 8'h00);
            wr(1'b0, 8'h60 + 8'(i));
            check("R5 lower released", {7'd0, int_out}, 8'h01);
            do_ack("R5 pair second", 8'h28 + 8'(j));
            wr(1'b0, 8'h60 + 8'(j));
            irq_in = '0;
            @(negedge clk);
         end
      end

      // R4 masked lines
      for (int l = 0; l < 8; l++) begin
         wr(1'b1, 8'(1 << l));
         irq_in = 8'(1 << l);
         @(negedge clk);
         check("R4 masked line silent", {7'd0, int_out}, 8'h00);
         rd_mask(v); check("R4 mask readback", v, 8'(1 << l));
         irq_in = '0;
         @(negedge clk);
      end
      wr(1'b1, 8'h00);

      // R10 non-specific end
      irq_in = 8'h02; @(negedge clk);
      do_ack("R10 first", 8'h29);
      irq_in = 8'h03; @(negedge clk);
      check("R10 higher preempts", {7'd0, int_out}, 8'h01);
      do_ack("R10 second", 8'h28);
      rd_cmd(8'h0B, v); check("R10 two in service", v, 8'h03);
      wr(1'b0, 8'h20);
      check("R8 selection persists", rd_data, 8'h02);
      wr(1'b0, 8'h20);
      check("R10 all ended", rd_data, 8'h00);
      irq_in = '0; @(negedge clk);

      // R11 spurious with line 7 masked
      wr(1'b1, 8'h80);
      irq_in = 8'h08; @(negedge clk);
      check("R11 raised", {7'd0, int_out}, 8'h01);
      irq_in = 8'h00; @(negedge clk);
      check("R11 dropped", {7'd0, int_out}, 8'h00);
      do_ack("R11 spurious", 8'h2F);
      rd_cmd(8'h0B, v); check("R11 in-service untouched", v, 8'h00);
      wr(1'b1, 8'h00);

      // R12 retrigger needs a new edge
      irq_in = 8'h10; @(negedge clk);
      do_ack("R12 first", 8'h2C);
      wr(1'b0, 8'h64);
      check("R12 held silent", {7'd0, int_out}, 8'h00);
      irq_in = 8'h00; @(negedge clk);
      irq_in = 8'h10; @(negedge clk);
      check("R12 new edge", {7'd0, int_out}, 8'h01);
      do_ack("R12 second", 8'h2C);
      wr(1'b0, 8'h64);
      irq_in = '0; @(negedge clk);

      // R7 auto end
      setup(8'h20, 8'h04, 8'h03);
      wr(1'b1, 8'h00);
      irq_in = 8'h20; @(negedge clk);
      do_ack("R7 auto", 8'h25);
      rd_cmd(8'h0B, v); check("R7 in-service cleared", v, 8'h00);
      irq_in = '0; @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule